// File: doc/BRIEF.md
# Posted-Write Queue with Read Bypass

This block sits between a write-through cache and a single memory bus. The cache hands it stores through a valid/ready port. Each accepted store is posted into a small first-in first-out queue, and the cache goes on without waiting for memory. The queue drains to memory one entry at a time, in the order the stores arrived. A store from a write-back cache that evicts a dirty block can use the same path, because an entry is simply an address and a data word.

Read misses from the cache take priority on the bus over posted writes. A write goes out only in a cycle where no read needs the bus. If a read asks for an address that still has a pending write, the block answers the read from the queue and does not use the bus. In this way the cache never sees a stale value from memory. A flush input makes the queue drain ahead of reads, and the empty flag shows when the drain is finished.

Top module: `wr_drain_buf`

## Requirements
- R1: Posted writes appear on the bus (`busReq`=1, `busWe`=1) in the order their stores were accepted, each with the address and data of that store. Memory ends up holding the last value stored to each address.
- R2: `stReady` is 1 whenever the queue holds fewer than DEPTH entries and no flush drain is in progress. A store offered while the queue is full is held off (`stReady`=0) for as long as the queue stays full.
- R3: When a read that is not answered from the queue is pending and no flush is active, the bus carries that read (`busWe`=0, `busAddr`=`rdAddr`) and not a queued write.
- R4: A queued write is driven onto the bus only in a cycle where no unanswered read is pending, or while a flush is active.
- R5: A read whose address matches a queued entry, or a store being accepted in the same cycle, is answered in that cycle (`rdAck`=1, `rdFwd`=1). The data comes from the newest matching store, and the read does not appear on the bus.
- R6: A read with no matching entry is sent to the bus. It completes in the cycle the bus acknowledges it, with `rdData` equal to `busRData` and `rdFwd`=0.
- R7: While `flush` is 1 and the queue is not empty, `stReady` is 0 and queued writes take the bus ahead of pending reads. A pending read is served only once the queue is empty.
- R8: After reset the queue is empty: `bufEmpty`=1, `bufFull`=0, `busReq`=0, `stReady`=1.
- R9: `bufEmpty` is 1 exactly when no entries are held and `bufFull` is 1 exactly when DEPTH entries are held. The two flags are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store offered by the cache |
| stReady | output | 1 | Store accepted this cycle when stValid is 1 |
| stAddr | input | AW | Store address |
| stData | input | DW | Store data |
| rdReq | input | 1 | Read miss request, held until rdAck |
| rdAddr | input | AW | Read address |
| rdAck | output | 1 | Read completes this cycle |
| rdData | output | DW | Read data, valid with rdAck |
| rdFwd | output | 1 | Read answered from the queue |
| flush | input | 1 | Drain the queue ahead of reads |
| bufEmpty | output | 1 | Queue holds no entries |
| bufFull | output | 1 | Queue holds DEPTH entries |
| busReq | output | 1 | Bus transaction requested |
| busWe | output | 1 | 1 = write, 0 = read |
| busAddr | output | AW | Bus address |
| busWData | output | DW | Bus write data |
| busAck | input | 1 | Bus accepts the request this cycle |
| busRData | input | DW | Bus read data, valid with busAck |

## Verification
The block is first driven with the bus acknowledgement held low, so the queue fills and its order and full stall can be observed. A read in that state must be forwarded from the queue. Duplicate addresses in the queue tell newest-entry forwarding apart from oldest-entry forwarding. A read miss with the queue full shows whether reads really win the bus. A flush that is raised together with a read shows the reversed priority, and a store and a read to the same address in the same cycle exercises the same-cycle bypass. A long mixed phase then toggles the acknowledgement at random and checks every drained write and every read result against a reference memory model.

// File: rtl/wr_drain_pkg.sv
package wr_drain_pkg;
  // Strobes from control to datapath, one bit each
  typedef struct packed {
    logic push;   // enqueue the offered store
    logic pop;    // head entry has been accepted by the bus
    logic rdBus;  // bus carries the pending read
    logic wrBus;  // bus carries the head write
    logic fwdSt;  // answer read from the store being accepted
    logic fwdQ;   // answer read from the newest matching queue entry
  } drainStrobe_t;
endpackage

// File: rtl/wr_drain_dp.sv
module wr_drain_dp
  import wr_drain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  drainStrobe_t  strb,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] busRData,
  output logic          qHit,
  output logic          stMatch,
  output logic          isFull,
  output logic          isEmpty,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWData,
  output logic [DW-1:0] rdData
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [AW-1:0] addrQ [DEPTH];
  logic [DW-1:0] dataQ [DEPTH];
  logic [PW-1:0] headPtr, tailPtr;
  logic [CW-1:0] count;
  logic [PW:0]   physIdx;
  logic [DW-1:0] qData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.push) tailPtr <= (tailPtr == LAST_IDX) ? '0 : tailPtr + 1'b1;
      if (strb.pop)  headPtr <= (headPtr == LAST_IDX) ? '0 : headPtr + 1'b1;
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrQ[tailPtr] <= stAddr;
      dataQ[tailPtr] <= stData;
    end
  end

  // Walk entries from oldest to newest; a later match overrides an earlier one
  always_comb begin
    qHit    = 1'b0;
    qData   = '0;
    physIdx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      physIdx = {1'b0, headPtr} + (PW+1)'(k);
      if (physIdx > {1'b0, LAST_IDX}) physIdx = physIdx - (PW+1)'(DEPTH);
      if ((CW'(k) < count) && (addrQ[physIdx[PW-1:0]] == rdAddr)) begin
        qHit  = 1'b1;
        qData = dataQ[physIdx[PW-1:0]];
      end
    end
  end

  assign stMatch  = (stAddr == rdAddr);
  assign isEmpty  = (count == '0);
  assign isFull   = (count == FULL_CNT);
  assign busAddr  = strb.wrBus ? addrQ[headPtr] : rdAddr;
  assign busWData = dataQ[headPtr];
  assign rdData   = strb.fwdSt ? stData : (strb.fwdQ ? qData : busRData);
endmodule

// File: rtl/wr_drain_ctrl.sv
module wr_drain_ctrl
  import wr_drain_pkg::*;
(
  input  logic         stValid,
  input  logic         rdReq,
  input  logic         flush,
  input  logic         busAck,
  input  logic         qHit,
  input  logic         stMatch,
  input  logic         isFull,
  input  logic         isEmpty,
  output logic         stReady,
  output logic         busReq,
  output logic         busWe,
  output logic         rdAck,
  output logic         rdFwd,
  output drainStrobe_t strb
);
  logic drainNow, anyFwd;

  always_comb begin
    drainNow   = flush && !isEmpty;
    stReady    = !isFull && !drainNow;
    strb.push  = stValid && stReady;
    strb.fwdSt = rdReq && strb.push && stMatch;
    strb.fwdQ  = rdReq && qHit && !strb.fwdSt;
    anyFwd     = strb.fwdSt || strb.fwdQ;
    // Reads own the bus unless a flush drain is running
    strb.rdBus = rdReq && !anyFwd && !drainNow;
    strb.wrBus = !isEmpty && !strb.rdBus;
    strb.pop   = strb.wrBus && busAck;
    busReq     = strb.rdBus || strb.wrBus;
    busWe      = strb.wrBus;
    rdAck      = anyFwd || (strb.rdBus && busAck);
    rdFwd      = anyFwd;
  end
endmodule

// File: rtl/wr_drain_buf.sv
module wr_drain_buf
  import wr_drain_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          stValid,
  output logic          stReady,
  input  logic [AW-1:0] stAddr,
  input  logic [DW-1:0] stData,
  input  logic          rdReq,
  input  logic [AW-1:0] rdAddr,
  output logic          rdAck,
  output logic [DW-1:0] rdData,
  output logic          rdFwd,
  input  logic          flush,
  output logic          bufEmpty,
  output logic          bufFull,
  output logic          busReq,
  output logic          busWe,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWData,
  input  logic          busAck,
  input  logic [DW-1:0] busRData
);
  drainStrobe_t strb;
  logic qHit, stMatch;

  wr_drain_ctrl u_ctrl (
    .stValid(stValid), .rdReq(rdReq), .flush(flush), .busAck(busAck),
    .qHit(qHit), .stMatch(stMatch), .isFull(bufFull), .isEmpty(bufEmpty),
    .stReady(stReady), .busReq(busReq), .busWe(busWe),
    .rdAck(rdAck), .rdFwd(rdFwd), .strb(strb)
  );

  wr_drain_dp #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr), .busRData(busRData),
    .qHit(qHit), .stMatch(stMatch), .isFull(bufFull), .isEmpty(bufEmpty),
    .busAddr(busAddr), .busWData(busWData), .rdData(rdData)
  );
endmodule

// File: rtl/wr_drain_chk.sv
module wr_drain_chk (
  input logic clk,
  input logic rstN,
  input logic stReady,
  input logic rdReq,
  input logic rdFwd,
  input logic flush,
  input logic bufEmpty,
  input logic bufFull,
  input logic busReq,
  input logic busWe
);
  assert_full_stalls_R2: assert property (@(posedge clk) disable iff (!rstN)
    bufFull |-> !stReady);

  assert_read_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdFwd && !flush) |-> (busReq && !busWe));

  assert_write_idle_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busWe && !flush) |-> !(rdReq && !rdFwd));

  assert_fwd_off_bus_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdFwd |-> !(busReq && !busWe));

  assert_flush_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !bufEmpty) |-> (!stReady && busReq && busWe));

  assert_flags_apart_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(bufFull && bufEmpty));

  assert_empty_no_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> !(busReq && busWe));
endmodule

bind wr_drain_buf wr_drain_chk u_chk (
  .clk(clk), .rstN(rstN), .stReady(stReady), .rdReq(rdReq), .rdFwd(rdFwd),
  .flush(flush), .bufEmpty(bufEmpty), .bufFull(bufFull),
  .busReq(busReq), .busWe(busWe)
);

// File: tb/wr_drain_buf_bench.sv
module wr_drain_buf_bench;
  localparam int DEPTH = 4;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stValid = 1'b0, rdReq = 1'b0, flush = 1'b0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [DW-1:0] stData = '0;
  logic stReady, rdAck, rdFwd, bufEmpty, bufFull, busReq, busWe, busAck;
  logic [DW-1:0] rdData, busWData, busRData;
  logic [AW-1:0] busAddr;
  logic ackEn = 1'b0;
  logic randAck = 1'b0;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] mem    [256];
  logic [DW-1:0] refMem [256];
  logic [AW+DW-1:0] expWr [$];
  logic [DW-1:0]    expRd [$];

  always #2 clk = ~clk;

  wr_drain_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wr_drain_buf (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stReady(stReady),
    .stAddr(stAddr), .stData(stData), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .rdFwd(rdFwd), .flush(flush),
    .bufEmpty(bufEmpty), .bufFull(bufFull), .busReq(busReq), .busWe(busWe),
    .busAddr(busAddr), .busWData(busWData), .busAck(busAck), .busRData(busRData)
  );

  // Memory model
  assign busAck   = busReq && ackEn;
  assign busRData = mem[busAddr];
  always @(posedge clk) if (busReq && busWe && busAck) mem[busAddr] <= busWData;

  always @(negedge clk) if (randAck) ackEn <= ($urandom % 3) != 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: compares bus writes and read results against the scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && busReq && busWe && busAck) begin
        if (expWr.size() == 0) check(1'b0, "R1 unexpected write", busAddr, 0);
        else begin
          logic [AW+DW-1:0] e;
          e = expWr.pop_front();
          check({busAddr, busWData} == e, "R1 write order", {busAddr, busWData}, e);
        end
      end
      if (rstN && rdAck) begin
        if (expRd.size() == 0) check(1'b0, "R6 unexpected read ack", rdData, 0);
        else begin
          logic [DW-1:0] e;
          e = expRd.pop_front();
          check(rdData == e, "R5/R6 read data", rdData, e);
        end
      end
      if (rstN && rdReq && !rdFwd && !flush && busReq)
        check(!busWe, "R3 read owns bus", busWe, 0);
    end
  end

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d;
    #1;
    while (!stReady) begin @(negedge clk); #1; end
    expWr.push_back({a, d});
    refMem[a] = d;
    @(negedge clk);
    stValid = 1'b0;
  endtask

  task automatic doRead(input logic [AW-1:0] a, output logic fwd);
    @(negedge clk);
    rdReq = 1'b1; rdAddr = a;
    expRd.push_back(refMem[a]);
    #1;
    while (!rdAck) begin @(negedge clk); #1; end
    fwd = rdFwd;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic waitEmpty();
    do begin @(negedge clk); #1; end while (!bufEmpty);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic f;
    int wrSeen, cyc;
    bit done;
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i) ^ 8'h5A;
      refMem[i] = DW'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R8 reset state
    check(bufEmpty == 1'b1, "R8 empty after reset", bufEmpty, 1);
    check(bufFull == 1'b0, "R8 not full after reset", bufFull, 0);
    check(busReq == 1'b0, "R8 bus idle after reset", busReq, 0);
    check(stReady == 1'b1, "R8 ready after reset", stReady, 1);

    // Fill with duplicate addresses while the bus never acknowledges
    ackEn = 1'b0;
    doStore(8'd20, 8'h11);
    doStore(8'd21, 8'h22);
    doStore(8'd20, 8'h33);
    #1;
    check(bufFull == 1'b0 && bufEmpty == 1'b0, "R9 partial flags", {bufFull, bufEmpty}, 0);
    check(stReady == 1'b1, "R2 ready below depth", stReady, 1);
    doStore(8'd22, 8'h44);
    #1;
    check(bufFull == 1'b1, "R9 full at depth", bufFull, 1);
    // R2 offered store is held off while full
    stValid = 1'b1; stAddr = 8'd99; stData = 8'hEE;
    for (int c = 0; c < 3; c++) begin
      #1;
      check(stReady == 1'b0, "R2 stall while full", stReady, 0);
      @(negedge clk);
    end
    stValid = 1'b0;

    // R5 newest matching entry forwarded
    doRead(8'd20, f);
    check(f == 1'b1, "R5 forwarded flag", f, 1);

    // R3 read miss wins the bus over a full queue
    @(negedge clk);
    ackEn = 1'b1; rdReq = 1'b1; rdAddr = 8'd50;
    expRd.push_back(refMem[50]);
    #1;
    check(busReq && !busWe && busAddr == 8'd50, "R3 read on bus first", {busReq, busWe}, 2);
    check(rdAck && !rdFwd, "R6 miss served by bus", {rdAck, rdFwd}, 2);
    @(negedge clk);
    rdReq = 1'b0;
    waitEmpty();
    check(mem[20] == 8'h33, "R1 newest value in memory", mem[20], 8'h33);
    check(mem[22] == 8'h44, "R1 last entry drained", mem[22], 8'h44);

    // R6 read after drain goes to memory
    doRead(8'd21, f);
    check(f == 1'b0, "R6 not forwarded after drain", f, 0);

    // R5 same-cycle store and read bypass
    ackEn = 1'b0;
    @(negedge clk);
    stValid = 1'b1; stAddr = 8'd60; stData = 8'h77;
    rdReq = 1'b1; rdAddr = 8'd60;
    expRd.push_back(8'h77);
    #1;
    check(rdAck && rdFwd && stReady, "R5 same-cycle bypass", {rdAck, rdFwd, stReady}, 7);
    expWr.push_back({8'd60, 8'h77});
    refMem[60] = 8'h77;
    @(negedge clk);
    stValid = 1'b0; rdReq = 1'b0;

    // R7 flush drains ahead of a read
    doStore(8'd30, 8'hA1);
    doStore(8'd31, 8'hA2);
    @(negedge clk);
    flush = 1'b1; rdReq = 1'b1; rdAddr = 8'd40; ackEn = 1'b1;
    expRd.push_back(refMem[40]);
    wrSeen = 0; cyc = 0; done = 1'b0;
    while (!done && cyc < 10) begin
      #1;
      if (!bufEmpty) check(!stReady, "R7 stores held during flush", stReady, 0);
      if (rdAck) begin
        done = 1'b1;
        check(wrSeen == 3, "R7 read after drain", wrSeen, 3);
        check(bufEmpty == 1'b1, "R7 empty flag", bufEmpty, 1);
      end else if (busReq && busWe && busAck) wrSeen++;
      @(negedge clk);
      cyc++;
    end
    check(done, "R7 read completed", done, 1);
    flush = 1'b0; rdReq = 1'b0;

    // Mixed traffic with random bus acknowledgement (R1 R5 R6)
    randAck = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 2 == 0) doStore(AW'($urandom % 8), DW'($urandom));
      else doRead(AW'($urandom % 8), f);
    end
    randAck = 1'b0;
    @(negedge clk);
    ackEn = 1'b1;
    waitEmpty();
    @(negedge clk);
    for (int a = 0; a < 8; a++)
      check(mem[a] == refMem[a], "R1 final memory image", mem[a], refMem[a]);
    check(expWr.size() == 0, "R1 all writes drained", expWr.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule